// File: doc/BRIEF.md
# Fused Multiply-Add NaN Selector

This block decides what a fused multiply-add `(a*b)+c` returns when one or more operands is a NaN, or when the product is infinity times zero. It examines the three single-precision operands, classifies each as a quiet NaN, a signaling NaN or neither, and applies one of four priority policies. The result is a 2-bit choice: 0 picks a, 1 picks b, 2 picks c, 3 picks the generated default NaN. An output multiplexer then turns that choice into the final 32-bit word. When the chosen operand is signaling, the multiplexer quiets it first. Computing the product and the sum is left to the datapath around the block.

A `snan_hi` input selects the quiet-bit polarity. Under normal polarity, fraction bit 22 set means quiet. Under inverted polarity, that bit set means signaling. The polarity changes the classification, the default NaN pattern, the quieting rule and, under one policy, the search order. A `dflt_mode` input forces the default NaN onto the result whatever the choice is. An invalid-operation flag is sticky and is cleared only by reset.

Each request is presented with `in_valid`. The choice, the result and a one-cycle `out_valid` strobe appear together one clock later. The block has no state machine. It is one registered stage: a classifier per operand, a priority unit, and a quieting multiplexer.

Top module: `fma_nan_select`

## Requirements
- R1: Operands are classified as follows, with exp = bits 30:23 and frac = bits 22:0. Under normal polarity (`snan_hi`=0), a NaN (exp all ones, frac nonzero) is quiet when bit 22 is 1 and signaling when bit 22 is 0. Under inverted polarity (`snan_hi`=1), a word with exp all ones and bit 22 set is signaling, and a NaN with bit 22 clear is quiet.
- R2: With `policy`=0, when `inf_x_zero` is set and c is a quiet NaN, `out_sel` is 3 and invalid is raised.
- R3: Otherwise, `policy`=0 selects the first match in this order: c signaling (2), a signaling (0), b signaling (1), c quiet (2), a quiet (0). If none matches it selects b (1).
- R4: With `policy`=1, `inf_x_zero` set gives `out_sel`=3 and raises invalid, whatever the operands are.
- R5: Otherwise, `policy`=1 under inverted polarity checks signaling NaNs first and then quiet NaNs, in the operand order a, b, c for both. If none matches it selects c.
- R6: Otherwise, `policy`=1 under normal polarity checks signaling NaNs in the order c, a, b, then quiet NaNs in the order c, a. If none matches it selects b.
- R7: With `policy`=2, `inf_x_zero` set raises invalid and selects c (2). Otherwise it selects a if a is any NaN, else c if c is any NaN, else b.
- R8: With `policy`=3, the block selects the first of a, b, c that is any NaN. If none is a NaN it selects c. `inf_x_zero` neither raises invalid nor changes the choice under this policy.
- R9: `invalid_flag` is sticky. It is set one clock after a request in which any operand is signaling, or in which an inf-times-zero rule above raised invalid. It stays set until reset and is 0 after reset.
- R10: When `dflt_mode` is set, or `out_sel` is 3, `out_res` is the default NaN: 0x7FC00000 under normal polarity, 0x7FBFFFFF under inverted polarity.
- R11: When the chosen operand is signaling, `out_res` is that operand with bit 22 set under normal polarity, and the default NaN under inverted polarity. Any other chosen operand passes through unchanged.
- R12: `out_sel`, `out_res` and `out_valid` are registered together one clock after `in_valid`. `out_valid` is a single-cycle strobe. `out_sel` and `out_res` hold their values while no request arrives, and all outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| policy | input | 2 | Priority policy, 0 to 3 |
| snan_hi | input | 1 | 1 = inverted quiet-bit polarity |
| dflt_mode | input | 1 | Force default NaN result |
| inf_x_zero | input | 1 | Product is infinity times zero |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| op_c | input | 32 | Addend |
| out_valid | output | 1 | Result strobe, one clock after request |
| out_sel | output | 2 | Choice: 0 a, 1 b, 2 c, 3 default NaN |
| out_res | output | 32 | Final result word |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
Two things can raise invalid in the same request: the inf-times-zero rule and a signaling operand. Both also decide the choice, so the bench presents `inf_x_zero` together with a signaling addend under each policy. It then judges `out_sel` against the policy order and checks that the sticky flag rises exactly once. The second overlap is the default-mode override landing on a request whose chosen operand would otherwise be quieted. There the result must be the default pattern and not the quieted operand. Random requests mix all four policies, both polarities and both mode bits, so these collisions also occur unprompted.

// File: rtl/fnp_pkg.sv
package fnp_pkg;

    typedef enum logic [1:0] {
        POL_ADDEND_FIRST = 2'd0,
        POL_POLARITY     = 2'd1,
        POL_MUL_PAIR     = 2'd2,
        POL_PLAIN        = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_DFLT = 2'd3
    } sel_e;

    typedef struct packed {
        logic any;
        logic quiet;
        logic sig;
    } nan_cls_t;

endpackage

// File: rtl/fnp_classify.sv
module fnp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    input  logic                  snan_hi,
    output fnp_pkg::nan_cls_t     cls
);
    localparam int QBIT = FRAC_W - 1;

    logic exp_ones;
    logic frac_nz;
    logic qb;

    always_comb begin
        exp_ones = &word[EXP_W+FRAC_W-1:FRAC_W];
        frac_nz  = |word[FRAC_W-1:0];
        qb       = word[QBIT];
        cls.any  = exp_ones && frac_nz;
        if (snan_hi) begin
            // bit set marks a signaling NaN
            cls.sig   = exp_ones && qb;
            cls.quiet = exp_ones && !qb && frac_nz;
        end else begin
            cls.quiet = exp_ones && qb;
            cls.sig   = exp_ones && !qb && frac_nz;
        end
    end

    // R1: the two kinds never overlap
    always_comb begin
        assert (!(cls.quiet && cls.sig)) else $error("p_cls_excl_r1");
    end
endmodule

// File: rtl/fnp_priority.sv
module fnp_priority (
    input  fnp_pkg::policy_e  policy,
    input  logic              snan_hi,
    input  logic              inf_x_zero,
    input  fnp_pkg::nan_cls_t ca,
    input  fnp_pkg::nan_cls_t cb,
    input  fnp_pkg::nan_cls_t cc,
    output fnp_pkg::sel_e     sel,
    output logic              iz_raise
);
    import fnp_pkg::*;

    always_comb begin
        sel      = SEL_B;
        iz_raise = 1'b0;
        unique case (policy)
            POL_ADDEND_FIRST: begin
                if (inf_x_zero && cc.quiet) begin
                    sel      = SEL_DFLT;
                    iz_raise = 1'b1;
                end else if (cc.sig)   sel = SEL_C;
                else if (ca.sig)       sel = SEL_A;
                else if (cb.sig)       sel = SEL_B;
                else if (cc.quiet)     sel = SEL_C;
                else if (ca.quiet)     sel = SEL_A;
                else                   sel = SEL_B;
            end
            POL_POLARITY: begin
                if (inf_x_zero) begin
                    sel      = SEL_DFLT;
                    iz_raise = 1'b1;
                end else if (snan_hi) begin
                    if (ca.sig)        sel = SEL_A;
                    else if (cb.sig)   sel = SEL_B;
                    else if (cc.sig)   sel = SEL_C;
                    else if (ca.quiet) sel = SEL_A;
                    else if (cb.quiet) sel = SEL_B;
                    else               sel = SEL_C;
                end else begin
                    if (cc.sig)        sel = SEL_C;
                    else if (ca.sig)   sel = SEL_A;
                    else if (cb.sig)   sel = SEL_B;
                    else if (cc.quiet) sel = SEL_C;
                    else if (ca.quiet) sel = SEL_A;
                    else               sel = SEL_B;
                end
            end
            POL_MUL_PAIR: begin
                if (inf_x_zero) begin
                    sel      = SEL_C;
                    iz_raise = 1'b1;
                end else if (ca.any) sel = SEL_A;
                else if (cc.any)     sel = SEL_C;
                else                 sel = SEL_B;
            end
            POL_PLAIN: begin
                if (ca.any)          sel = SEL_A;
                else if (cb.any)     sel = SEL_B;
                else                 sel = SEL_C;
            end
        endcase
    end

    // R8: the plain policy never produces the default code
    always_comb begin
        assert (!(policy == POL_PLAIN && (sel == SEL_DFLT || iz_raise)))
            else $error("p_plain_no_dflt_r8");
    end
endmodule

// File: rtl/fnp_quiet_mux.sv
module fnp_quiet_mux #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  fnp_pkg::sel_e                  sel,
    input  logic [2:0][EXP_W+FRAC_W:0]     ops,
    input  logic [2:0]                     op_sig,
    input  logic                           snan_hi,
    input  logic                           dflt_mode,
    output logic [EXP_W+FRAC_W:0]          res
);
    import fnp_pkg::*;
    localparam int W    = 1 + EXP_W + FRAC_W;
    localparam int QBIT = FRAC_W - 1;
    localparam logic [W-1:0] DNAN_NORM = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] DNAN_INV  = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    logic [W-1:0] dnan;
    logic [W-1:0] pick;
    logic         pick_sig;

    always_comb begin
        dnan     = snan_hi ? DNAN_INV : DNAN_NORM;
        pick     = ops[0];
        pick_sig = 1'b0;
        if (sel != SEL_DFLT) begin
            pick     = ops[sel];
            pick_sig = op_sig[sel];
        end
        if (dflt_mode || sel == SEL_DFLT) begin
            res = dnan;
        end else if (pick_sig) begin
            if (snan_hi) res = dnan;
            else begin
                res       = pick;
                res[QBIT] = 1'b1;
            end
        end else begin
            res = pick;
        end
    end
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               policy,
    input  logic                     snan_hi,
    input  logic                     dflt_mode,
    input  logic                     inf_x_zero,
    input  logic [EXP_W+FRAC_W:0]    op_a,
    input  logic [EXP_W+FRAC_W:0]    op_b,
    input  logic [EXP_W+FRAC_W:0]    op_c,
    output logic                     out_valid,
    output logic [1:0]               out_sel,
    output logic [EXP_W+FRAC_W:0]    out_res,
    output logic                     invalid_flag
);
    import fnp_pkg::*;
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int N_OPS = 3;
    localparam int QBIT  = FRAC_W - 1;

    logic [N_OPS-1:0][W-1:0] ops;
    nan_cls_t [N_OPS-1:0]    cls;
    logic [N_OPS-1:0]        sig_vec;
    sel_e                    sel_nxt;
    logic                    iz_raise;
    logic [W-1:0]            res_nxt;

    assign ops = {op_c, op_b, op_a};

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        fnp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word(ops[i]), .snan_hi(snan_hi), .cls(cls[i])
        );
        assign sig_vec[i] = cls[i].sig;
    end

    fnp_priority u_prio (
        .policy(policy_e'(policy)), .snan_hi(snan_hi), .inf_x_zero(inf_x_zero),
        .ca(cls[0]), .cb(cls[1]), .cc(cls[2]),
        .sel(sel_nxt), .iz_raise(iz_raise)
    );

    fnp_quiet_mux #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mux (
        .sel(sel_nxt), .ops(ops), .op_sig(sig_vec), .snan_hi(snan_hi),
        .dflt_mode(dflt_mode), .res(res_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_sel      <= 2'd0;
            out_res      <= '0;
            invalid_flag <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sel <= sel_nxt;
                out_res <= res_nxt;
                if (iz_raise || (|sig_vec)) invalid_flag <= 1'b1;
            end
        end
    end

    p_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_sel) && $stable(out_res));
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_flag |=> invalid_flag);
    p_pol1_iz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && policy == 2'd1 && inf_x_zero |=> out_sel == 2'd3 && invalid_flag);
    p_dflt_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && dflt_mode |=> out_res == {1'b0, {EXP_W{1'b1}}, !$past(snan_hi), {(FRAC_W-1){$past(snan_hi)}}});
    p_quiet_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !snan_hi |=> !((&out_res[W-2:FRAC_W]) && !out_res[QBIT] && (|out_res[QBIT-1:0])));
endmodule

// File: tb/fma_nan_select_bench.sv
module fma_nan_select_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  policy = 2'd0;
    logic        snan_hi = 1'b0;
    logic        dflt_mode = 1'b0;
    logic        inf_x_zero = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        out_valid;
    logic [1:0]  out_sel;
    logic [31:0] out_res;
    logic        invalid_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_flag = 1'b0;
    logic [1:0]  exp_sel_last = 2'd0;
    logic [31:0] exp_res_last = '0;
    bit   done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fma_nan_select u_fma_nan_select (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .policy(policy),
        .snan_hi(snan_hi), .dflt_mode(dflt_mode), .inf_x_zero(inf_x_zero),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .out_valid(out_valid),
        .out_sel(out_sel), .out_res(out_res), .invalid_flag(invalid_flag)
    );

    function automatic bit is_q(logic [31:0] v, bit inv);
        bit top = (v[30:23] == 8'hFF);
        if (inv) return top && !v[22] && (v[21:0] != 0);
        return top && v[22];
    endfunction
    function automatic bit is_s(logic [31:0] v, bit inv);
        bit top = (v[30:23] == 8'hFF);
        if (inv) return top && v[22];
        return top && !v[22] && (v[21:0] != 0);
    endfunction

    // returns {raise, code}
    function automatic logic [2:0] ref_pick(logic [1:0] p, bit inv, bit iz,
                                            logic [31:0] a, logic [31:0] b, logic [31:0] c);
        bit aq = is_q(a, inv), as_ = is_s(a, inv);
        bit bq = is_q(b, inv), bs = is_s(b, inv);
        bit cq = is_q(c, inv), cs = is_s(c, inv);
        case (p)
            2'd0: begin
                if (iz && cq) return 3'b1_11;
                if (cs) return 3'd2; if (as_) return 3'd0; if (bs) return 3'd1;
                if (cq) return 3'd2; if (aq) return 3'd0; return 3'd1;
            end
            2'd1: begin
                if (iz) return 3'b1_11;
                if (inv) begin
                    if (as_) return 3'd0; if (bs) return 3'd1; if (cs) return 3'd2;
                    if (aq) return 3'd0; if (bq) return 3'd1; return 3'd2;
                end
                if (cs) return 3'd2; if (as_) return 3'd0; if (bs) return 3'd1;
                if (cq) return 3'd2; if (aq) return 3'd0; return 3'd1;
            end
            2'd2: begin
                if (iz) return 3'b1_10;
                if (aq || as_) return 3'd0; if (cq || cs) return 3'd2; return 3'd1;
            end
            default: begin
                if (aq || as_) return 3'd0; if (bq || bs) return 3'd1; return 3'd2;
            end
        endcase
    endfunction

    function automatic logic [31:0] ref_res(logic [1:0] code, bit inv, bit dm,
                                            logic [31:0] a, logic [31:0] b, logic [31:0] c);
        logic [31:0] dn = inv ? 32'h7FBFFFFF : 32'h7FC00000;
        logic [31:0] v;
        if (dm || code == 2'd3) return dn;
        v = (code == 2'd0) ? a : (code == 2'd1) ? b : c;
        if (is_s(v, inv)) return inv ? dn : (v | 32'h0040_0000);
        return v;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic run(string req, logic [1:0] p, bit inv, bit dm, bit iz,
                       logic [31:0] a, logic [31:0] b, logic [31:0] c);
        logic [2:0]  pk;
        logic [31:0] er;
        pk = ref_pick(p, inv, iz, a, b, c);
        er = ref_res(pk[1:0], inv, dm, a, b, c);
        if (pk[2] || is_s(a, inv) || is_s(b, inv) || is_s(c, inv)) exp_flag = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; policy = p; snan_hi = inv; dflt_mode = dm; inf_x_zero = iz;
        op_a = a; op_b = b; op_c = c;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, {req, " valid"}, 32'(out_valid), 32'd1);
        chk(out_sel == pk[1:0], {req, " sel"}, 32'(out_sel), 32'(pk[1:0]));
        chk(out_res == er, {req, " res"}, out_res, er);
        chk(invalid_flag == exp_flag, {req, " R9 flag"}, 32'(invalid_flag), 32'(exp_flag));
        exp_sel_last = pk[1:0];
        exp_res_last = er;
    endtask

    function automatic logic [31:0] gen(int k);
        logic [31:0] r = $urandom;
        case (k)
            0: begin r[30:23] = 8'h80 + 8'($urandom_range(0, 100)); return r; end
            1: return {r[31], 8'hFF, 23'd0};
            2: return {r[31], 8'hFF, 1'b1, r[21:0]};
            3: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
            default: return {r[31], 8'hFF, 23'h400000};
        endcase
    endfunction

    localparam logic [31:0] QN = 32'h7FC0_1234;  // quiet under normal polarity
    localparam logic [31:0] SN = 32'h7F80_0055;  // signaling under normal polarity
    localparam logic [31:0] NUM = 32'h3F80_0000;

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_sel == 0 && out_res == 0 && invalid_flag == 0,
            "R12 reset", out_res, 32'd0);
        rst_n = 1'b1;
        // no signaling, no flag
        run("R8 plain quiet b", 2'd3, 0, 0, 1, NUM, QN, QN ^ 32'h1);
        run("R1 R3 quiet c before a", 2'd0, 0, 0, 0, QN, NUM, 32'hFFC0_0001);
        // idle hold
        @(negedge clk);
        chk(out_valid == 0 && out_sel == exp_sel_last && out_res == exp_res_last,
            "R12 hold", out_res, exp_res_last);
        run("R2 iz with quiet c", 2'd0, 0, 0, 1, NUM, NUM, QN);
        run("R3 snan b over quiet c", 2'd0, 0, 0, 0, QN, SN, QN);
        run("R11 quieted c", 2'd0, 0, 0, 1, NUM, NUM, SN);
        run("R4 iz forces default", 2'd1, 0, 0, 1, NUM, NUM, NUM);
        run("R5 inverted a,b,c snan", 2'd1, 1, 0, 0, 32'h7F80_0011, 32'h7FC0_0000, 32'h7FC0_0001);
        run("R6 normal c first", 2'd1, 0, 0, 0, SN, SN, SN ^ 32'h2);
        run("R7 iz passes c", 2'd2, 0, 0, 1, QN, QN, SN);
        run("R7 a then c", 2'd2, 0, 0, 0, NUM, QN, QN ^ 32'h4);
        run("R10 default mode", 2'd0, 0, 1, 0, SN, NUM, NUM);
        run("R10 inverted default", 2'd3, 1, 1, 0, NUM, NUM, NUM);
        run("R11 inverted snan to default", 2'd3, 1, 0, 0, 32'hFFC0_0000, NUM, NUM);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b, c;
            a = gen($urandom_range(0, 4));
            b = gen($urandom_range(0, 4));
            c = gen($urandom_range(0, 4));
            run("R1-random", 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 7) == 0), 1'($urandom_range(0, 3) == 0), a, b, c);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule